// File: doc/BRIEF.md
# Instruction-Driven Serial Register Port

This block is a slave serial port that gives an external controller access to a small register file. The controller drives a serial clock, a single bidirectional data line and an optional active-low chip select. Every transaction opens with an 8-bit instruction byte. That byte sets the direction, the number of data bytes (one to three) and the first register address. The stated number of bytes then moves between the line and the register file. After each byte the address steps by one, up or down.

All three pins are synchronised into the system clock domain, and edges of the serial clock are detected there. The serial clock must run at no more than a tenth of the system clock. Incoming bits are taken on falling edges. Outgoing bits are updated on rising edges. Two run-time inputs, normally driven from the command register, choose the address direction and the bit order inside data bytes. On the register side the port presents an address, write data, a one-cycle write strobe, and a combinational read-data return. If a transaction stops part-way and no clock edge arrives for a programmable number of cycles, the port drops back to waiting for an instruction and leaves the registers untouched.

Top module: `serial_reg_port`

## Requirements
- R1: The instruction byte is always shifted most-significant bit first. Bit 7 selects the direction (0 write, 1 read), bits 6:5 hold the byte count code, bit 4 is ignored, and bits 3:0 give the first register address.
- R2: Byte count code 00 moves one byte, 01 moves two and 10 moves three. Code 11 is treated as three. A write produces exactly one single-cycle `regWrEn` pulse per data byte.
- R3: After each data byte the register address goes to the next higher value (modulo 16) when `bdDown`=0, and to the next lower value when `bdDown`=1.
- R4: During a write, a byte stored to address 0100 or 0101 (the command register) is always followed by the next higher address, whatever `bdDown` is. A read honours `bdDown` there, so a two-byte read from 0100 with `bdDown`=1 returns 0100 and then 0011.
- R5: With `lsbFirst`=0 each data byte travels most-significant bit first. With `lsbFirst`=1 it travels least-significant bit first. This holds for both reads and writes.
- R6: `sdioIn` is sampled on falling edges of `sclkIn`. `sdioOut` changes only after rising edges of `sclkIn`.
- R7: On a read, `sdioOe` rises after the last instruction bit and falls after the last falling edge of the last data byte. It stays low at all other times and throughout writes.
- R8: While `csN` is high, serial clock edges are ignored. Raising `csN` neither releases `sdioOe` nor resets the transaction in progress.
- R9: If a transaction is in progress and no serial clock edge arrives for `TIMEOUT_CLKS` system cycles, the port clears `sdioOe` and waits for a new instruction. It issues no register write.
- R10: After reset `sdioOe`, `sdioOut` and `regWrEn` are low, and the port waits for an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclkIn | input | 1 | Serial clock from the controller |
| sdioIn | input | 1 | Serial data line, input side |
| csN | input | 1 | Active-low chip select |
| sdioOut | output | 1 | Serial data line, output value |
| sdioOe | output | 1 | Output enable for the data line |
| bdDown | input | 1 | 1: address steps downward between bytes |
| lsbFirst | input | 1 | 1: data bytes shifted least-significant bit first |
| regAddr | output | 4 | Register file address |
| regWrData | output | 8 | Register write data |
| regWrEn | output | 1 | Register write strobe, one cycle per byte |
| regRdData | input | 8 | Register read data for `regAddr` (combinational) |

## Verification
The bench sweeps byte counts, both address directions, both bit orders and start addresses that include the command register pair and the wrap at 0000/1111. A design that applied `bdDown` to command-register writes would scatter bytes below 0100. A design that mirrored the wrong byte under `lsbFirst` would return bit-reversed data. A design that stopped the byte count one byte early or late would miss a register or overwrite a neighbour. The timeout is exercised both mid-instruction and mid-read: a port that kept stale shift state would misread the next instruction, and one that kept `sdioOe` high would fight the bus. Clock pulses with `csN` high must leave the registers unchanged, and `csN` rising mid-read must not drop the output enable.

// File: rtl/serial_reg_port_pkg.sv
package serial_reg_port_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 4;
  localparam int BIT_CNT_W = $clog2(BYTE_W);

  typedef enum logic [1:0] {PH_INSTR, PH_WRITE, PH_READ} portPhase_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic instrPhase;  // shifting the instruction byte
    logic sampleBit;   // take one input bit
    logic instrDone;   // last instruction bit taken this cycle
    logic writeByte;   // last bit of a write byte taken this cycle
    logic stepAddr;    // advance the register address
    logic loadRead;    // capture read data for the current address
    logic presentBit;  // put the next output bit on the line
  } portStb_t;
endpackage

// File: rtl/serial_reg_port_ctrl.sv
module serial_reg_port_ctrl
  import serial_reg_port_pkg::*;
#(
  parameter int TIMEOUT_CLKS = 250000,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclkIn,
  input  logic                 sdioIn,
  input  logic                 csN,
  input  logic                 instrRw,
  input  logic [1:0]           instrMb,
  output logic                 bitIn,
  output logic [BIT_CNT_W-1:0] bitCnt,
  output logic                 oeQ,
  output portStb_t             stb
);
  localparam int IDLE_W = $clog2(TIMEOUT_CLKS + 1);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

  logic [SYNC_STAGES:0]   sclkSh;
  logic [SYNC_STAGES-1:0] sdioSh;
  logic [SYNC_STAGES-1:0] csSh;
  portPhase_t             phase;
  logic [1:0]             bytesLeft;
  logic                   loadPend, wrPend;
  logic [IDLE_W-1:0]      idleCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSh <= '0;
      sdioSh <= '0;
      csSh   <= '1;
    end else begin
      sclkSh <= {sclkSh[SYNC_STAGES-1:0], sclkIn};
      sdioSh <= {sdioSh[SYNC_STAGES-2:0], sdioIn};
      csSh   <= {csSh[SYNC_STAGES-2:0], csN};
    end
  end

  logic active, riseEv, fallEv, lastBit, byteEnd, timedOut, busy;
  assign active  = !csSh[SYNC_STAGES-1];
  assign riseEv  = active && sclkSh[SYNC_STAGES-1] && !sclkSh[SYNC_STAGES];
  assign fallEv  = active && !sclkSh[SYNC_STAGES-1] && sclkSh[SYNC_STAGES];
  assign bitIn   = sdioSh[SYNC_STAGES-1];
  assign lastBit = fallEv && (bitCnt == LAST_BIT);
  assign byteEnd = lastBit && (phase != PH_INSTR);
  assign busy    = (phase != PH_INSTR) || (bitCnt != '0);
  assign timedOut = busy && !(riseEv || fallEv) &&
                    (idleCnt == IDLE_W'(TIMEOUT_CLKS - 1));

  always_comb begin
    stb            = '0;
    stb.instrPhase = (phase == PH_INSTR);
    stb.sampleBit  = fallEv && (phase != PH_READ);
    stb.instrDone  = lastBit && (phase == PH_INSTR);
    stb.writeByte  = lastBit && (phase == PH_WRITE);
    stb.stepAddr   = wrPend || (lastBit && (phase == PH_READ));
    stb.loadRead   = loadPend;
    stb.presentBit = riseEv && (phase == PH_READ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_INSTR;
      bitCnt    <= '0;
      bytesLeft <= '0;
      loadPend  <= 1'b0;
      wrPend    <= 1'b0;
      oeQ       <= 1'b0;
      idleCnt   <= '0;
    end else begin
      wrPend   <= stb.writeByte;
      loadPend <= 1'b0;
      if (!busy || riseEv || fallEv || timedOut) idleCnt <= '0;
      else idleCnt <= idleCnt + 1'b1;
      if (timedOut) begin
        phase  <= PH_INSTR;
        bitCnt <= '0;
        oeQ    <= 1'b0;
      end else if (fallEv) begin
        bitCnt <= bitCnt + 1'b1;
        if (stb.instrDone) begin
          phase     <= instrRw ? PH_READ : PH_WRITE;
          bytesLeft <= (instrMb == 2'b11) ? 2'd2 : instrMb;
          oeQ       <= instrRw;
          loadPend  <= instrRw;
        end else if (byteEnd) begin
          if (bytesLeft == 2'd0) begin
            phase <= PH_INSTR;
            oeQ   <= 1'b0;
          end else begin
            bytesLeft <= bytesLeft - 1'b1;
            loadPend  <= (phase == PH_READ);
          end
        end
      end
    end
  end

  AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    oeQ |-> (phase == PH_READ)); // R7
  AST_TIMEOUT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    idleCnt < IDLE_W'(TIMEOUT_CLKS)); // R9
  AST_BIT_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    fallEv |=> (bitCnt == $past(bitCnt) + 1'b1)); // R6
  AST_CS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !timedOut) |=> ($stable(phase) && $stable(bitCnt))); // R8
endmodule

// File: rtl/serial_reg_port_data.sv
module serial_reg_port_data
  import serial_reg_port_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  portStb_t             stb,
  input  logic                 bitIn,
  input  logic [BIT_CNT_W-1:0] bitCnt,
  input  logic                 bdDown,
  input  logic                 lsbFirst,
  input  logic [BYTE_W-1:0]    regRdData,
  output logic                 instrRw,
  output logic [1:0]           instrMb,
  output logic                 sdioOut,
  output logic [ADDR_W-1:0]    regAddr,
  output logic [BYTE_W-1:0]    regWrData,
  output logic                 regWrEn
);
  logic [BYTE_W-1:0] instrSh, instrNext, dataSh, dataNext, rdSh;
  logic              isWrite, cmdReg, goDown;
  logic [BIT_CNT_W-1:0] outIdx;

  assign instrNext = {instrSh[BYTE_W-2:0], bitIn};
  assign dataNext  = lsbFirst ? {bitIn, dataSh[BYTE_W-1:1]}
                              : {dataSh[BYTE_W-2:0], bitIn};
  assign instrRw   = instrNext[7];
  assign instrMb   = instrNext[6:5];
  assign cmdReg    = (regAddr[ADDR_W-1:1] == 3'b010);
  assign goDown    = bdDown && !(isWrite && cmdReg);
  assign outIdx    = lsbFirst ? bitCnt : (BIT_CNT_W'(BYTE_W - 1) - bitCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      instrSh   <= '0;
      dataSh    <= '0;
      rdSh      <= '0;
      isWrite   <= 1'b0;
      regAddr   <= '0;
      regWrData <= '0;
      regWrEn   <= 1'b0;
      sdioOut   <= 1'b0;
    end else begin
      regWrEn <= stb.writeByte;
      if (stb.sampleBit) begin
        if (stb.instrPhase) instrSh <= instrNext;
        else dataSh <= dataNext;
      end
      if (stb.instrDone) begin
        regAddr <= instrNext[ADDR_W-1:0];
        isWrite <= !instrNext[7];
      end else if (stb.stepAddr) begin
        regAddr <= goDown ? regAddr - 1'b1 : regAddr + 1'b1;
      end
      if (stb.writeByte) regWrData <= dataNext;
      if (stb.loadRead) rdSh <= regRdData;
      if (stb.presentBit) sdioOut <= rdSh[outIdx];
    end
  end

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn); // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stepAddr && !stb.instrDone) |=>
      ((regAddr == $past(regAddr) + 1'b1) || (regAddr == $past(regAddr) - 1'b1))); // R3
  AST_CMD_WRITE_UP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stepAddr && isWrite && cmdReg) |=> (regAddr == $past(regAddr) + 1'b1)); // R4
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
  import serial_reg_port_pkg::*;
#(
  parameter int TIMEOUT_CLKS = 250000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclkIn,
  input  logic       sdioIn,
  input  logic       csN,
  output logic       sdioOut,
  output logic       sdioOe,
  input  logic       bdDown,
  input  logic       lsbFirst,
  output logic [3:0] regAddr,
  output logic [7:0] regWrData,
  output logic       regWrEn,
  input  logic [7:0] regRdData
);
  portStb_t             stb;
  logic                 bitIn, instrRw;
  logic [1:0]           instrMb;
  logic [BIT_CNT_W-1:0] bitCnt;

  serial_reg_port_ctrl #(.TIMEOUT_CLKS(TIMEOUT_CLKS), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .sdioIn(sdioIn), .csN(csN),
    .instrRw(instrRw), .instrMb(instrMb), .bitIn(bitIn), .bitCnt(bitCnt),
    .oeQ(sdioOe), .stb(stb));

  serial_reg_port_data uData (
    .clk(clk), .rstN(rstN), .stb(stb), .bitIn(bitIn), .bitCnt(bitCnt),
    .bdDown(bdDown), .lsbFirst(lsbFirst), .regRdData(regRdData),
    .instrRw(instrRw), .instrMb(instrMb), .sdioOut(sdioOut),
    .regAddr(regAddr), .regWrData(regWrData), .regWrEn(regWrEn));

  AST_NO_WRITE_WHILE_OE: assert property (@(posedge clk) disable iff (!rstN)
    sdioOe |-> !regWrEn); // R7
endmodule

// File: tb/serial_reg_port_test.sv
`timescale 1ns/1ps
module serial_reg_port_test;
  localparam int TMO = 300;
  localparam int HALF = 8;

  logic clk = 0, rstN = 0, sclkIn = 0, sdioIn = 0, csN = 0, bdDown = 0, lsbFirst = 0;
  logic sdioOut, sdioOe, regWrEn;
  logic [3:0] regAddr;
  logic [7:0] regWrData, regRdData;
  logic [7:0] regs [16];
  int checks = 0, errors = 0, wrCount = 0;
  bit done = 0;

  always #10 clk = ~clk;

  serial_reg_port #(.TIMEOUT_CLKS(TMO)) uut (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .sdioIn(sdioIn), .csN(csN),
    .sdioOut(sdioOut), .sdioOe(sdioOe), .bdDown(bdDown), .lsbFirst(lsbFirst),
    .regAddr(regAddr), .regWrData(regWrData), .regWrEn(regWrEn), .regRdData(regRdData));

  assign regRdData = regs[regAddr];
  always @(posedge clk) if (regWrEn) begin
    regs[regAddr] <= regWrData;
    wrCount <= wrCount + 1;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendByte(logic [7:0] b, bit lsb);
    for (int i = 0; i < 8; i++) begin
      sclkIn = 1; sdioIn = lsb ? b[i] : b[7-i];
      tick(HALF);
      sclkIn = 0;
      tick(HALF);
    end
  endtask

  task automatic readByte(bit lsb, output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      sclkIn = 1;
      tick(HALF);
      if (lsb) b[i] = sdioOut; else b[7-i] = sdioOut;
      sclkIn = 0;
      tick(HALF);
    end
  endtask

  function automatic logic [3:0] nxt(logic [3:0] a, bit down, bit wr);
    if (down && !(wr && a[3:1] == 3'b010)) return a - 4'd1;
    return a + 4'd1;
  endfunction

  initial begin
    int starts [7] = '{0, 2, 4, 5, 9, 13, 15};
    logic [7:0] rd;
    logic [7:0] vals [3];
    logic [3:0] a;
    int w0, seed;
    for (int i = 0; i < 16; i++) regs[i] = 8'h00;
    tick(3);
    // R10 reset state
    check(sdioOe == 0, "R10 oe", sdioOe, 0);
    check(regWrEn == 0, "R10 wren", regWrEn, 0);
    check(sdioOut == 0, "R10 out", sdioOut, 0);
    rstN = 1;
    tick(4);
    seed = 1;
    // write sweep: R1 R2 R3 R4 R5
    foreach (starts[s]) for (int mb = 0; mb < 3; mb++)
      for (int bd = 0; bd < 2; bd++) for (int ls = 0; ls < 2; ls++) begin
        bdDown = bd[0]; lsbFirst = ls[0];
        w0 = wrCount;
        sendByte({1'b0, mb[1:0], 1'b1, 4'(starts[s])}, 0);
        for (int k = 0; k <= mb; k++) begin
          vals[k] = 8'(seed * 37 + k * 91 + 5); seed++;
          sendByte(vals[k], ls[0]);
          check(sdioOe == 0, "R7 write oe", sdioOe, 0);
        end
        tick(4);
        a = 4'(starts[s]);
        for (int k = 0; k <= mb; k++) begin
          check(regs[a] == vals[k], (a[3:1] == 3'b010 && bd == 1) ? "R4 write" : "R3 R5 write",
                regs[a], vals[k]);
          a = nxt(a, bd[0], 1);
        end
        check(wrCount - w0 == mb + 1, "R2 strobes", wrCount - w0, mb + 1);
      end
    // read sweep: R1 R3 R4 R5 R6 R7
    for (int i = 0; i < 16; i++) regs[i] = 8'(8'hC3 ^ (i * 29 + 7));
    foreach (starts[s]) for (int mb = 0; mb < 3; mb++)
      for (int bd = 0; bd < 2; bd++) for (int ls = 0; ls < 2; ls++) begin
        bdDown = bd[0]; lsbFirst = ls[0];
        w0 = wrCount;
        sendByte({1'b1, mb[1:0], 1'b0, 4'(starts[s])}, 0);
        check(sdioOe == 1, "R7 oe rise", sdioOe, 1);
        a = 4'(starts[s]);
        for (int k = 0; k <= mb; k++) begin
          readByte(ls[0], rd);
          check(rd == regs[a], (a[3:1] == 3'b010 && bd == 1) ? "R4 read" : "R5 R6 read",
                rd, regs[a]);
          a = nxt(a, bd[0], 0);
        end
        check(sdioOe == 0, "R7 oe fall", sdioOe, 0);
        check(wrCount == w0, "R7 no write", wrCount, w0);
      end
    bdDown = 0; lsbFirst = 0;
    // R2 code 11 counts as three bytes
    w0 = wrCount;
    sendByte(8'b0110_1000, 0);
    sendByte(8'h11, 0); sendByte(8'h22, 0); sendByte(8'h33, 0);
    tick(4);
    check(wrCount - w0 == 3, "R2 code11", wrCount - w0, 3);
    check(regs[10] == 8'h33, "R2 code11 last", regs[10], 8'h33);
    // R8 edges with csN high are ignored
    w0 = wrCount;
    csN = 1; tick(4);
    sendByte(8'b0000_0001, 0); sendByte(8'hEE, 0);
    csN = 0; tick(4);
    check(wrCount == w0, "R8 cs ignore", wrCount, w0);
    check(regs[1] != 8'hEE, "R8 reg kept", regs[1], 0);
    sendByte(8'b0000_0001, 0); sendByte(8'h5C, 0); tick(4);
    check(regs[1] == 8'h5C, "R8 after cs", regs[1], 8'h5C);
    // R8 csN high mid-read keeps oe and state
    sendByte(8'b1000_0110, 0);
    for (int i = 0; i < 3; i++) begin sclkIn = 1; tick(HALF); sclkIn = 0; tick(HALF); end
    csN = 1; tick(20);
    check(sdioOe == 1, "R8 oe held", sdioOe, 1);
    sclkIn = 1; tick(HALF); sclkIn = 0; tick(HALF);
    csN = 0; tick(4);
    for (int i = 0; i < 5; i++) begin sclkIn = 1; tick(HALF); sclkIn = 0; tick(HALF); end
    check(sdioOe == 0, "R8 read completes", sdioOe, 0);
    // R9 timeout mid-instruction
    for (int i = 0; i < 4; i++) begin sclkIn = 1; sdioIn = 1; tick(HALF); sclkIn = 0; tick(HALF); end
    tick(TMO + 20);
    sendByte(8'b0000_0011, 0); sendByte(8'hA7, 0); tick(4);
    check(regs[3] == 8'hA7, "R9 resync", regs[3], 8'hA7);
    // R9 timeout mid-read drops oe, no write
    w0 = wrCount;
    sendByte(8'b1010_0000, 0);
    for (int i = 0; i < 3; i++) begin sclkIn = 1; tick(HALF); sclkIn = 0; tick(HALF); end
    tick(TMO + 20);
    check(sdioOe == 0, "R9 oe cleared", sdioOe, 0);
    check(wrCount == w0, "R9 no write", wrCount, w0);
    // R9 timeout mid-write leaves second register
    regs[13] = 8'h42;
    sendByte(8'b0010_1100, 0); sendByte(8'h99, 0);
    for (int i = 0; i < 5; i++) begin sclkIn = 1; sdioIn = 0; tick(HALF); sclkIn = 0; tick(HALF); end
    tick(TMO + 20);
    check(regs[13] == 8'h42, "R9 partial byte dropped", regs[13], 8'h42);
    sendByte(8'b1000_1100, 0); readByte(0, rd);
    check(rd == 8'h99, "R9 first byte kept", rd, 8'h99);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule